// File: doc/BRIEF.md
# USB host frame interval timer

This block paces the frame events of a full-speed or low-speed USB host port. A down-counter runs on the PHY clock and raises a one-cycle frame tick once per programmed interval. Each tick is tagged as a start-of-frame request in full-speed mode or as a keep-alive request in low-speed mode. An 11-bit frame number advances on every tick.

Software sets two fields through a small write port: a 2-bit PHY clock select and a 16-bit interval. Until an interval has been accepted, the block takes its period from the clock select: 48000 clocks for the 48 MHz setting and 6000 clocks for the 6 MHz setting. These are 1 ms worth of PHY clocks. A write to the interval field is accepted only while the port is enabled. A clock select that is reserved, or not allowed for the current speed, stops the ticks. The counter is frozen at its reload value while the port is disabled or the clock select is invalid.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset `tick_o` is 0 and `frame_num_o` is 0. The clock select resets to 01 (48 MHz) and no interval is programmed, so with the port disabled `count_o` reads 47999.
- R2: Clock select encoding: 01 selects 48 MHz and 10 selects 6 MHz. With no programmed interval, ticks are 48000 cycles apart for 01 and 6000 cycles apart for 10.
- R3: In full-speed mode (`low_speed_i`=0) only 01 is a valid clock select. In low-speed mode 01 and 10 are valid. With an invalid select, no tick occurs and `count_o` stays constant.
- R4: An interval write (`wr_sel_i`=1, value in `wr_data_i`) while `port_en_i`=0 is ignored. `count_o` keeps showing the previous reload value.
- R5: An interval write while the port is enabled overrides the default. Ticks are then N cycles apart for N≥1, and an interval of 0 behaves as 1.
- R6: `count_o` counts down by one per cycle from N-1 to 0. `tick_o` is high exactly in the cycle in which `count_o` is 0.
- R7: While the port is disabled, `count_o` holds N-1 and no tick occurs. After `port_en_i` rises, the first tick is visible after N-1 clock edges.
- R8: `kind_o` is 1 (keep-alive) in low-speed mode and 0 (start-of-frame) in full-speed mode.
- R9: `frame_num_o` increments on every tick and wraps from 2047 to 0.
- R10: An interval written while the counter is running does not disturb the current countdown. The new interval applies from the next reload onward.
- R11: A clock select write (`wr_sel_i`=0, value in `wr_data_i[1:0]`) is accepted whether or not the port is enabled.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 1 | Field select: 0 clock select, 1 interval |
| wr_data_i | input | 16 | Write data |
| port_en_i | input | 1 | Port enabled |
| low_speed_i | input | 1 | 1 low-speed, 0 full-speed |
| tick_o | output | 1 | Frame event, one cycle |
| kind_o | output | 1 | 1 keep-alive, 0 start-of-frame |
| count_o | output | 16 | Current countdown value |
| frame_num_o | output | 11 | Frame number |

## Verification
A write changes the configuration at the next rising edge. The counter and the frame number are registers, so they change one edge after their cause. `tick_o` is decoded from the counter and is due in the same cycle that `count_o` reads zero. After the port is enabled, that cycle comes N-1 edges later. The bench drives inputs and samples outputs on falling edges. It counts falling edges between ticks, so a measured spacing equals the interval in cycles. Each expected value is taken at the first falling edge after the rising edge that is meant to produce it.

// File: rtl/ufr_pkg.sv
package ufr_pkg;
  typedef enum logic [1:0] {
    CS_RSV0 = 2'b00,
    CS_48M  = 2'b01,
    CS_6M   = 2'b10,
    CS_RSV3 = 2'b11
  } clk_sel_e;

  localparam logic SEL_CSEL = 1'b0;
  localparam logic SEL_IVL  = 1'b1;
endpackage

// File: rtl/ufr_cfg.sv
module ufr_cfg
  import ufr_pkg::*;
#(
  parameter int unsigned IVL_W   = 16,
  parameter int unsigned DEF_48  = 48000,
  parameter int unsigned DEF_6   = 6000,
  parameter int unsigned IVL_RST = 60000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [IVL_W-1:0] wr_data_i,
  input  logic             port_en_i,
  input  logic             low_speed_i,
  output logic             valid_o,
  output logic [IVL_W-1:0] reload_o
);
  clk_sel_e         csel_q;
  logic [IVL_W-1:0] ivl_q;
  logic             prog_q;
  logic [IVL_W-1:0] active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csel_q <= CS_48M;
      ivl_q  <= IVL_W'(IVL_RST);
      prog_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CSEL) begin
        csel_q <= clk_sel_e'(wr_data_i[1:0]);
      end else if (port_en_i) begin
        ivl_q  <= wr_data_i;
        prog_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (low_speed_i) valid_o = (csel_q == CS_48M) || (csel_q == CS_6M);
    else             valid_o = (csel_q == CS_48M);
  end

  always_comb begin
    if (prog_q)                active = ivl_q;
    else if (csel_q == CS_6M)  active = IVL_W'(DEF_6);
    else                       active = IVL_W'(DEF_48);
    reload_o = (active == '0) ? '0 : active - 1'b1;
  end

  p_wr_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_IVL && !port_en_i) |=> ($stable(ivl_q) && $stable(prog_q)));

  p_csel_any_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CSEL) |=> (csel_q == clk_sel_e'($past(wr_data_i[1:0]))));
endmodule

// File: rtl/ufr_down.sv
module ufr_down #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 47999
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (!run_i)          cnt_q <= reload_i;
    else if (cnt_q == '0)     cnt_q <= reload_i;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_single_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_i != '0) |=> !tick_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/ufr_fnum.sv
module ufr_fnum #(
  parameter int unsigned FN_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [FN_W-1:0] fn_o
);
  logic [FN_W-1:0] fn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fn_q <= '0;
    else if (tick_i) fn_q <= fn_q + 1'b1;
  end

  assign fn_o = fn_q;

  p_inc_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (fn_q == FN_W'($past(fn_q) + 1'b1)));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(fn_q));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int unsigned IVL_W   = 16,
  parameter int unsigned FN_W    = 11,
  parameter int unsigned DEF_48  = 48000,
  parameter int unsigned DEF_6   = 6000,
  parameter int unsigned IVL_RST = 60000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [IVL_W-1:0] wr_data_i,
  input  logic             port_en_i,
  input  logic             low_speed_i,
  output logic             tick_o,
  output logic             kind_o,
  output logic [IVL_W-1:0] count_o,
  output logic [FN_W-1:0]  frame_num_o
);
  logic             cfg_valid;
  logic [IVL_W-1:0] reload;
  logic             run;

  ufr_cfg #(
    .IVL_W(IVL_W), .DEF_48(DEF_48), .DEF_6(DEF_6), .IVL_RST(IVL_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .port_en_i(port_en_i), .low_speed_i(low_speed_i),
    .valid_o(cfg_valid), .reload_o(reload)
  );

  assign run = port_en_i && cfg_valid;

  ufr_down #(.W(IVL_W), .RST_VAL(DEF_48 - 1)) u_down (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(run), .reload_i(reload),
    .tick_o(tick_o), .cnt_o(count_o)
  );

  ufr_fnum #(.FN_W(FN_W)) u_fnum (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick_o), .fn_o(frame_num_o)
  );

  // token type follows the speed the port runs at
  assign kind_o = low_speed_i;

  p_no_tick_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid |-> !tick_o);

  p_no_tick_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> !tick_o);

  p_tick_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (count_o == '0));
endmodule

// File: tb/sim_usb_frame_timer.sv
`timescale 1ns/1ps
module sim_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        port_en = 1'b0;
  logic        ls = 1'b0;
  logic        tick, kind;
  logic [15:0] cnt;
  logic [10:0] fn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_frame_timer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .port_en_i(port_en), .low_speed_i(ls),
    .tick_o(tick), .kind_o(kind), .count_o(cnt), .frame_num_o(fn)
  );

  typedef struct packed {
    logic        ls;
    logic [1:0]  cs;
    logic [15:0] ivl;
    logic [15:0] gap;
    logic        kind;
  } vec_t;

  // programmed intervals: speed, clock select, interval, expected spacing, token type
  localparam vec_t VEC [6] = '{
    '{1'b0, 2'd1, 16'd10, 16'd10, 1'b0},
    '{1'b1, 2'd1, 16'd7,  16'd7,  1'b1},
    '{1'b1, 2'd2, 16'd3,  16'd3,  1'b1},
    '{1'b0, 2'd1, 16'd1,  16'd1,  1'b0},
    '{1'b0, 2'd1, 16'd0,  16'd1,  1'b0},
    '{1'b1, 2'd2, 16'd25, 16'd25, 1'b1}
  };

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // call at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic gap(output int n, output int bad);
    logic [15:0] prev;
    n = 0; bad = 0; prev = cnt;
    do begin
      @(negedge clk);
      n++;
      if (n > 1 && !tick && cnt != prev - 16'd1) bad++;
      prev = cnt;
    end while (!tick);
  endtask

  task automatic idle_check(input string req, input int cycles);
    int seen = 0;
    int moved = 0;
    logic [15:0] c0;
    @(negedge clk);
    @(negedge clk);
    c0 = cnt;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) seen++;
      if (cnt != c0) moved++;
    end
    chk(req, seen == 0 && moved == 0, seen + moved, 0);
  endtask

  initial begin
    #(180000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, bad, seen, wrapped, errs;
    logic [15:0] c0;
    logic [10:0] prev_fn;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tick", tick == 1'b0, tick, 0);
    chk("R1 frame", fn == 11'd0, fn, 0);
    chk("R1 count", cnt == 16'd47999, cnt, 47999);

    // R4: interval write while disabled must not change reload
    wr(1'b1, 16'd5);
    repeat (3) @(negedge clk);
    chk("R4 ignored", cnt == 16'd47999, cnt, 47999);
    idle_check("R7 held while disabled", 50);

    // R7: first tick after N-1 edges
    port_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 60000);
    chk("R7 first tick", n == 47999, n, 47999);
    chk("R6 zero at tick", cnt == 16'd0, cnt, 0);
    chk("R8 fs kind", kind == 1'b0, kind, 0);
    gap(n, bad);
    chk("R2 48MHz default", n == 48000, n, 48000);
    chk("R6 countdown", bad == 0, bad, 0);

    // R2 6 MHz default in low-speed mode, R11 select written while disabled
    port_en = 1'b0; ls = 1'b1;
    @(negedge clk);
    wr(1'b0, 16'd2);
    @(negedge clk);
    chk("R11 csel while disabled", cnt == 16'd5999, cnt, 5999);
    port_en = 1'b1;
    wait_tick();
    chk("R8 ls kind", kind == 1'b1, kind, 1);
    gap(n, bad);
    chk("R2 6MHz default", n == 6000, n, 6000);

    // R3 invalid selects
    ls = 1'b0;
    idle_check("R3 fs with 10", 200);
    ls = 1'b1;
    wr(1'b0, 16'd3);
    idle_check("R3 ls with 11", 200);
    wr(1'b0, 16'd0);
    idle_check("R3 ls with 00", 200);

    // R5 programmed intervals
    foreach (VEC[i]) begin
      port_en = 1'b0; ls = VEC[i].ls;
      @(negedge clk);
      wr(1'b0, {14'd0, VEC[i].cs});
      port_en = 1'b1;
      wr(1'b1, VEC[i].ivl);
      wait_tick();
      gap(n, bad);
      chk($sformatf("R5 vec%0d spacing", i), n == int'(VEC[i].gap), n, VEC[i].gap);
      chk($sformatf("R8 vec%0d kind", i), kind == VEC[i].kind, kind, VEC[i].kind);
      chk($sformatf("R6 vec%0d countdown", i), bad == 0 && cnt == 16'd0, bad + cnt, 0);
    end

    // R10 write during a running frame
    wr(1'b1, 16'd40);
    wait_tick();
    repeat (5) @(negedge clk);
    c0 = cnt;
    wr(1'b1, 16'd5);
    chk("R10 countdown undisturbed", cnt == c0 - 16'd1, cnt, c0 - 16'd1);
    wait_tick();
    gap(n, bad);
    chk("R10 new interval", n == 5, n, 5);

    // R9 wrap with a tick every cycle
    wr(1'b1, 16'd1);
    repeat (10) @(negedge clk);
    prev_fn = fn; wrapped = 0; errs = 0; seen = 0;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk);
      if (fn != prev_fn + 11'd1) errs++;
      if (prev_fn == 11'd2047 && fn == 11'd0) wrapped++;
      if (!tick) seen++;
      prev_fn = fn;
    end
    chk("R9 increment", errs == 0, errs, 0);
    chk("R9 wrap", wrapped == 1, wrapped, 1);
    chk("R5 interval 1 continuous", seen == 0, seen, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule